// File: doc/BRIEF.md
# Dual-Clock Aspect-Switchable Dual-Port RAM

This block is a 256-bit memory with one write port and one read port. Each port runs on its own clock, and the two ports work at the same time without depending on each other. A single organisation input sets the array's shape. When it is low, the array is 32 bytes. When it is high, the array is 64 nibbles. Both ports always carry a 6-bit address and an 8-bit data bus, whichever shape is selected.

Each port has a polarity input that picks the clock edge it acts on. A low polarity input selects the rising edge and a high one selects the falling edge. The write port stores data on its active edge when the enable is high. The read port registers the addressed word on its active edge. A read that lands on the same edge as a write to the same row returns the contents held before that write. An active-low asynchronous reset clears only the read output register. The stored contents are undefined until they are written.

Top module: `twin_clock_aspect_ram`

## Requirements
- R1: With `narrow_mode` low, the array holds 32 bytes. A write stores all eight bits of `wr_data` in row `wr_addr[4:0]`. A read returns all eight bits of row `rd_addr[4:0]`.
- R2: With `narrow_mode` low, bit 5 of `wr_addr` and bit 5 of `rd_addr` have no effect.
- R3: With `narrow_mode` high, row `wr_addr[4:0]` is written with `wr_data[3:0]` only. `wr_addr[5]`=0 selects the low nibble (bits 3:0) and `wr_addr[5]`=1 selects the high nibble (bits 7:4). The other nibble of that row keeps its value.
- R4: With `narrow_mode` high, a read places the nibble chosen by `rd_addr[5]` on `rd_data[3:0]`, using the same encoding as R3, and drives `rd_data[7:4]` to zero.
- R5: A write takes place only if `wr_en` is high at the active write edge. Without it, the memory is unchanged.
- R6: `rd_data` changes only at the active read edge. It then shows the location addressed at that edge.
- R7: `wr_clk_fall`=0 makes the write port act on the rising edge of `wr_clk`. `wr_clk_fall`=1 makes it act on the falling edge.
- R8: `rd_clk_fall`=0 makes the read port act on the rising edge of `rd_clk`. `rd_clk_fall`=1 makes it act on the falling edge.
- R9: When a read and a write to the same location fall on the same instant, the read returns the data held before that write.
- R10: While `rst_n` is low, `rd_data` is zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of the read register |
| narrow_mode | input | 1 | 0: 32x8 organisation, 1: 64x4 organisation |
| wr_clk | input | 1 | Write port clock |
| wr_clk_fall | input | 1 | 1 selects the falling edge of `wr_clk` |
| wr_en | input | 1 | Write enable, sampled at the active write edge |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data (bits 3:0 only in 64x4 organisation) |
| rd_clk | input | 1 | Read port clock |
| rd_clk_fall | input | 1 | 1 selects the falling edge of `rd_clk` |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
A write becomes part of the stored state at the active write edge that sees `wr_en` high. A read address presented before an active read edge appears on `rd_data` right after that edge, so the read latency is one edge.

The bench applies each stimulus just after the inactive edge of the port's clock and withdraws or changes it just after the active edge. The only edge inside that window is the active one, so a design that acts on the wrong edge produces a mismatch. Expected read values go into a queue when the address is driven. The monitor takes one item from the queue half a nanosecond after each active read edge. The read clock is the inverse of the write clock, so the two polarity settings that differ make the ports' active edges coincide, and the bench uses exactly those settings to test the old-data rule.

// File: rtl/aspect_ram_pkg.sv
`timescale 1ns/1ps
package aspect_ram_pkg;
  localparam int LANE_W = 4;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
  localparam int ROWS   = 32;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int ADDR_W = ROW_W + $clog2(LANES);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;

  typedef enum logic {ORG_BYTE = 1'b0, ORG_NIBBLE = 1'b1} org_e;

  // Row index is the low address bits in both organisations.
  function automatic row_t row_of(addr_t a);
    return a[ROW_W-1:0];
  endfunction

  // Lane picked by the top address bit; meaningful only for nibbles.
  function automatic logic lane_sel(addr_t a);
    return a[ADDR_W-1];
  endfunction

  // Which lanes of the row a write touches.
  function automatic lane_mask_t lane_mask(addr_t a, org_e org, logic en);
    lane_mask_t m;
    m = '0;
    if (en) begin
      if (org == ORG_BYTE) m = '1;
      else m[lane_sel(a)] = 1'b1;
    end
    return m;
  endfunction

  // Data offered to every lane; in nibble mode the low nibble is replicated.
  function automatic word_t spread_data(word_t d, org_e org);
    if (org == ORG_BYTE) return d;
    return {LANES{d[LANE_W-1:0]}};
  endfunction

  // Output word formed from a stored row.
  function automatic word_t pick_read(word_t w, addr_t a, org_e org);
    word_t r;
    if (org == ORG_BYTE) begin
      r = w;
    end else begin
      r = '0;
      r[LANE_W-1:0] = w[lane_sel(a)*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/arm_edge_pick.sv
`timescale 1ns/1ps
module arm_edge_pick (
  input  logic clk_in,
  input  logic fall_sel,
  output logic clk_act
);
  // A rising edge of clk_act marks the port's active edge.
  assign clk_act = clk_in ^ fall_sel;
endmodule

// File: rtl/arm_write_path.sv
`timescale 1ns/1ps
module arm_write_path
  import aspect_ram_pkg::*;
(
  input  logic       wclk_act,
  input  logic       rst_n,
  input  org_e       org,
  input  logic       wr_en,
  input  addr_t      wr_addr,
  input  word_t      wr_data,
  output row_t       wr_row,
  output lane_mask_t lane_we,
  output word_t      lane_data
);
  assign wr_row    = row_of(wr_addr);
  assign lane_we   = lane_mask(wr_addr, org, wr_en);
  assign lane_data = spread_data(wr_data, org);

  // R3: a nibble write touches exactly the lane named by the top address bit
  assert_nibble_lane_R3: assert property (@(posedge wclk_act) disable iff (!rst_n)
    (wr_en && org == ORG_NIBBLE) |-> ($countones(lane_we) == 1 && lane_we[LANES-1] == wr_addr[ADDR_W-1]));

  // R1: a byte write touches the whole row
  assert_byte_full_R1: assert property (@(posedge wclk_act) disable iff (!rst_n)
    (wr_en && org == ORG_BYTE) |-> (&lane_we));
endmodule

// File: rtl/arm_lane_store.sv
`timescale 1ns/1ps
module arm_lane_store
  import aspect_ram_pkg::*;
(
  input  logic       wclk_act,
  input  lane_mask_t lane_we,
  input  row_t       wr_row,
  input  word_t      lane_data,
  input  row_t       rd_row,
  output word_t      rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [ROWS];
    always_ff @(posedge wclk_act) begin
      if (lane_we[g]) cells[wr_row] <= lane_data[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = cells[rd_row];
  end
endmodule

// File: rtl/arm_read_path.sv
`timescale 1ns/1ps
module arm_read_path
  import aspect_ram_pkg::*;
(
  input  logic  rclk_act,
  input  logic  rst_n,
  input  org_e  org,
  input  addr_t rd_addr,
  input  word_t rd_word,
  output row_t  rd_row,
  output word_t rd_q
);
  word_t picked;

  assign rd_row = row_of(rd_addr);
  assign picked = pick_read(rd_word, rd_addr, org);

  always_ff @(posedge rclk_act or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= picked;
  end

  // R4: a nibble read leaves the upper half of the output at zero
  assert_upper_zero_R4: assert property (@(posedge rclk_act) disable iff (!rst_n)
    (org == ORG_NIBBLE) |=> (rd_q[WORD_W-1:LANE_W] == '0));

  // R6: a byte read shows the row the storage offered at the previous active edge
  assert_byte_follows_R6: assert property (@(posedge rclk_act) disable iff (!rst_n)
    (org == ORG_BYTE) |=> (rd_q === $past(rd_word)));
endmodule

// File: rtl/twin_clock_aspect_ram.sv
`timescale 1ns/1ps
module twin_clock_aspect_ram
  import aspect_ram_pkg::*;
(
  input  logic              rst_n,
  input  logic              narrow_mode,
  input  logic              wr_clk,
  input  logic              wr_clk_fall,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_clk_fall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic       wclk_act;
  logic       rclk_act;
  org_e       org;
  row_t       wr_row;
  row_t       rd_row;
  lane_mask_t lane_we;
  word_t      lane_data;
  word_t      rd_word;

  assign org = org_e'(narrow_mode);

  arm_edge_pick u_wedge (.clk_in(wr_clk), .fall_sel(wr_clk_fall), .clk_act(wclk_act));
  arm_edge_pick u_redge (.clk_in(rd_clk), .fall_sel(rd_clk_fall), .clk_act(rclk_act));

  arm_write_path u_wpath (
    .wclk_act (wclk_act),
    .rst_n    (rst_n),
    .org      (org),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_row   (wr_row),
    .lane_we  (lane_we),
    .lane_data(lane_data)
  );

  arm_lane_store u_store (
    .wclk_act (wclk_act),
    .lane_we  (lane_we),
    .wr_row   (wr_row),
    .lane_data(lane_data),
    .rd_row   (rd_row),
    .rd_word  (rd_word)
  );

  arm_read_path u_rpath (
    .rclk_act(rclk_act),
    .rst_n   (rst_n),
    .org     (org),
    .rd_addr (rd_addr),
    .rd_word (rd_word),
    .rd_row  (rd_row),
    .rd_q    (rd_data)
  );
endmodule

// File: tb/tb_twin_clock_aspect_ram.sv
`timescale 1ns/1ps
module tb_twin_clock_aspect_ram;
  logic       rst_n, narrow, wr_en, winv, rinv;
  logic       wclk, rclk;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int checks = 0;
  int errors = 0;

  typedef struct {logic [7:0] v; string tag;} exp_t;
  exp_t q[$];
  logic [7:0] mb [32];   // bench model: one byte per row

  twin_clock_aspect_ram dut (
    .rst_n(rst_n), .narrow_mode(narrow),
    .wr_clk(wclk), .wr_clk_fall(winv), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rclk), .rd_clk_fall(rinv), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial wclk = 1'b0;
  always #2 wclk = ~wclk;          // 250 MHz
  assign rclk = ~wclk;             // differing polarity settings make edges coincide

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic w_active();   if (winv) @(negedge wclk); else @(posedge wclk); endtask
  task automatic w_inactive(); if (winv) @(posedge wclk); else @(negedge wclk); endtask
  task automatic r_active();   if (rinv) @(negedge rclk); else @(posedge rclk); endtask
  task automatic r_inactive(); if (rinv) @(posedge rclk); else @(negedge rclk); endtask

  // Expected read value, restated from R1..R4 in bench terms
  function automatic logic [7:0] exp_of(input logic [5:0] a);
    logic [7:0] row_val;
    row_val = mb[a % 32];
    if (!narrow) return row_val;
    return (a >= 32) ? {4'h0, row_val[7:4]} : {4'h0, row_val[3:0]};
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    if (!narrow) mb[a % 32] = d;
    else if (a >= 32) mb[a % 32][7:4] = d[3:0];
    else mb[a % 32][3:0] = d[3:0];
  endtask

  // Inputs are valid only across the active write edge (R7)
  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input logic en);
    w_inactive(); #0.5;
    wr_en = en; wr_addr = a; wr_data = d;
    w_active(); #0.5;
    if (en) model_write(a, d);
    wr_en = 1'b0; wr_addr = ~a; wr_data = ~d;
  endtask

  // Address valid only across the active read edge (R8); expectation queued
  task automatic do_read(input logic [5:0] a, input string tag);
    exp_t e;
    r_inactive(); #0.5;
    rd_addr = a;
    e.v = exp_of(a);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    r_active(); #1;
  endtask

  // Monitor: compare once per active read edge
  initial begin
    forever begin
      exp_t e;
      r_active(); #0.5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(rd_data === e.v, e.tag, rd_data, e.v);
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; narrow = 1'b0; wr_en = 1'b0; winv = 1'b0; rinv = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    #10;
    chk(rd_data == 8'h00, "R10 reset", rd_data, 8'h00);
    #3 rst_n = 1'b1;

    for (int p = 0; p < 4; p++) begin
      winv = p[0]; rinv = p[1];
      #12;
      // Byte organisation, bit 5 varied on both ports (R1, R2, R7, R8)
      narrow = 1'b0;
      for (int r = 0; r < 32; r++)
        do_write(6'(r | ((r & 1) << 5)), 8'((r * 37 + p * 11 + 5) & 255), 1'b1);
      for (int r = 0; r < 32; r++)
        do_read(6'(r | (((r + 1) & 1) << 5)), "R1/R2/R7/R8 byte");
      drain();
      // Disabled write leaves the row alone (R5)
      do_write(6'd5, ~mb[5], 1'b0);
      do_read(6'd5, "R5 no enable");
      do_read(6'd37, "R5 no enable");
      drain();
      // Nibble organisation, upper data bits carry junk (R3, R4)
      narrow = 1'b1;
      for (int a = 0; a < 64; a++)
        do_write(6'(a), 8'({4'(4'h9 ^ a[3:0]), 4'((a * 7 + p) & 15)}), 1'b1);
      for (int a = 0; a < 64; a++)
        do_read(6'(a), "R4/R6 nibble");
      drain();
      // Byte view of nibble writes shows placement (R3)
      narrow = 1'b0;
      #8;
      for (int r = 0; r < 32; r++)
        do_read(6'(r), "R3 placement");
      drain();
      // Single nibble rewrite keeps its neighbour (R3)
      narrow = 1'b1;
      do_write(6'd44, 8'hF3, 1'b1);
      narrow = 1'b0;
      do_read(6'd12, "R3 neighbour kept");
      drain();
      // Coincident read and write on one row (R9)
      if (winv != rinv) begin
        fork
          do_write(6'd9, 8'(8'h5A ^ p), 1'b1);
          do_read(6'd9, "R9 old data");
        join
        do_read(6'd9, "R9 new data after");
        drain();
      end
    end

    // Asynchronous clear mid-run (R10)
    rst_n = 1'b0;
    #0.5;
    chk(rd_data == 8'h00, "R10 async clear", rd_data, 8'h00);
    #5 rst_n = 1'b1;
    #10;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule